// File: doc/BRIEF.md
# Coprocessor-0 Trap and Interrupt Controller

This block holds the system-control state of a small in-order 32-bit RISC core and decides when the core must leave its normal instruction stream. The pipeline presents a synchronous exception request with a 5-bit cause code, the PC of the faulting instruction, the current fetch PC, delay-slot and branch-taken flags and a coprocessor number. A separate strobe checks computed branch targets for alignment. External interrupt lines are sampled into pending bits. When a trap is taken, the block saves the return PC, updates the cause word and fault address, pushes the privilege/interrupt-enable stack, and emits a one-cycle redirect that carries the handler vector and also serves as the pipeline flush request.

Software reaches the registers through a move-to/move-from port addressed by a 5-bit index. Writes pass through a fixed per-register write mask. The return-from-exception strobe pops the mode stack. A three-state machine controls sequencing. BOOT emits the reset redirect and always moves to RUN. RUN accepts traps and register traffic, and moves to REDIR when a trap fires. REDIR emits the trap redirect and always moves back to RUN.

Top module: `cp0_trap_unit`

## Requirements
- R1: While reset is low and in the first cycle after it is released, redirect_vld is 1 with redirect_pc 0xBFC00000, and it then drops. Reset clears the status, cause, return-PC, fault-address, jump-target, debug-control and all four breakpoint registers.
- R2: A trap redirects to 0xBFC00180 when status bit 22 (boot vector select) is 1, and to 0x80000080 when it is 0, whatever the cause code.
- R3: A synchronous trap loads the return PC with exc_pc and writes the cause word under the trap mask 0xF000007C: code in [6:2], branch-taken in bit 30, coprocessor number in [29:28] and delay-slot flag in bit 31. Cause bits outside that mask are kept.
- R4: When the delay-slot flag is set, the return PC is exc_pc minus 4 and the jump-target register captures fetch_pc.
- R5: Taking a trap shifts status bits [5:0] left by two (zeros in [1:0]), leaving every other status bit unchanged.
- R6: A return-from-exception strobe keeps status bits [5:4] and replaces [3:0] with the old [5:2].
- R7: When br_chk is high and br_tgt[1:0] is nonzero, the block takes a trap with code 4 and clears the delay-slot, branch-taken and coprocessor fields. Both the return PC and the fault address take br_tgt.
- R8: Software writes merge through fixed masks: status 0xF04FFF3F, cause 0x00000300, debug control 0xFF80F03F. The four breakpoint registers take all 32 bits.
- R9: Writes to the jump-target register have no effect. Index 15 reads 0x00000002. A read strobe to an unimplemented index takes a trap with code 10.
- R10: Cause bits [15:10] follow irq_lines one cycle later. A new assertion on any line holds off interrupt recognition until the next insn_step pulse. An interrupt trap (code 0, return PC exc_pc) is taken when status bit 0 is set and a cause bit in [15:8] is set whose status mask bit in [15:8] is also set.
- R11: Trap priority is exc_req first, then a misaligned branch target, then an unimplemented-register read, then an interrupt.
- R12: The trap redirect is high for exactly one cycle, the cycle after the trap is accepted. Requests presented during a redirect cycle are ignored.
- R13: Register indices are 3 and 5 (breakpoint PC and data address), 6 (jump target), 7 (debug control), 8 (fault address), 9 and 11 (breakpoint data and PC masks), 12 (status), 13 (cause), 14 (return PC) and 15 (processor ID). reg_rdata shows the register at reg_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 5 | Cause code for exc_req |
| exc_pc | input | 32 | PC of the instruction being trapped |
| fetch_pc | input | 32 | PC currently being fetched |
| in_delay | input | 1 | Trapped instruction sits in a branch delay slot |
| br_taken | input | 1 | The branch owning the delay slot was taken |
| cop_num | input | 2 | Coprocessor number of the trapped instruction |
| br_chk | input | 1 | br_tgt is a branch target to be checked |
| br_tgt | input | 32 | Computed branch target |
| irq_lines | input | NIRQ | External interrupt levels |
| insn_step | input | 1 | One instruction has completed |
| rfe | input | 1 | Return-from-exception strobe |
| reg_wr | input | 1 | Move-to write strobe |
| reg_rd | input | 1 | Move-from read strobe |
| reg_idx | input | 5 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx |
| redirect_vld | output | 1 | Redirect and flush pulse |
| redirect_pc | output | 32 | Redirect target |

## Verification
The assertions assume that the pipeline does not pulse rfe in the same cycle as a trap request, and that software does not write the status or cause register while a trap is being accepted. The stimulus raises each request for a single cycle in RUN, with all other strobes low, except in the scenarios that test priority and redirect-cycle blocking. The interrupt scenarios arm an interrupt either through the status write or through insn_step, so the cycle in which the trap fires is known in advance.

// File: rtl/cp0_trap_pkg.sv
`timescale 1ns/1ps
package cp0_trap_pkg;
    localparam int XW = 32;

    typedef enum logic [1:0] {ST_BOOT, ST_RUN, ST_REDIR} trap_st_e;

    localparam logic [XW-1:0] BOOT_PC    = 32'hBFC0_0000;
    localparam logic [XW-1:0] VEC_BOOT   = 32'hBFC0_0180;
    localparam logic [XW-1:0] VEC_NORM   = 32'h8000_0080;
    localparam logic [XW-1:0] PRID_VAL   = 32'h0000_0002;
    localparam logic [XW-1:0] SR_WMASK   = 32'hF04F_FF3F;
    localparam logic [XW-1:0] CA_WMASK   = 32'h0000_0300;
    localparam logic [XW-1:0] DBG_WMASK  = 32'hFF80_F03F;
    localparam logic [XW-1:0] TRAP_WMASK = 32'hF000_007C;
    localparam int            SR_BEV     = 22;
    localparam int            MODE_W     = 6;

    localparam logic [4:0] IX_BKPC  = 5'd3;
    localparam logic [4:0] IX_BKDA  = 5'd5;
    localparam logic [4:0] IX_JTGT  = 5'd6;
    localparam logic [4:0] IX_DBG   = 5'd7;
    localparam logic [4:0] IX_FADR  = 5'd8;
    localparam logic [4:0] IX_BKDM  = 5'd9;
    localparam logic [4:0] IX_BKPM  = 5'd11;
    localparam logic [4:0] IX_STAT  = 5'd12;
    localparam logic [4:0] IX_CAUSE = 5'd13;
    localparam logic [4:0] IX_RPC   = 5'd14;
    localparam logic [4:0] IX_PID   = 5'd15;

    localparam logic [4:0] CODE_INT  = 5'd0;
    localparam logic [4:0] CODE_ALGN = 5'd4;
    localparam logic [4:0] CODE_RSVD = 5'd10;

    function automatic logic idx_known(input logic [4:0] ix);
        return (ix == IX_BKPC) || (ix == IX_BKDA) || (ix == IX_JTGT) ||
               (ix == IX_DBG)  || (ix == IX_FADR) || (ix == IX_BKDM) ||
               (ix == IX_BKPM) || (ix == IX_STAT) || (ix == IX_CAUSE) ||
               (ix == IX_RPC)  || (ix == IX_PID);
    endfunction

    function automatic logic [XW-1:0] trap_word(input logic [4:0] code, input logic bd,
                                                input logic bt, input logic [1:0] ce);
        logic [XW-1:0] w;
        w        = '0;
        w[31]    = bd;
        w[30]    = bt;
        w[29:28] = ce;
        w[6:2]   = code;
        return w;
    endfunction
endpackage

// File: rtl/cp0_status_reg.sv
`timescale 1ns/1ps
module cp0_status_reg
    import cp0_trap_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          wr_en,
    input  logic [XW-1:0] wr_data,
    output logic [XW-1:0] sr_q
);
    localparam int KEEP_LO = MODE_W - 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (push) begin
            sr_q[MODE_W-1:0] <= {sr_q[KEEP_LO-1:0], 2'b00};
        end else if (pop) begin
            sr_q[MODE_W-1:0] <= {sr_q[MODE_W-1:KEEP_LO], sr_q[MODE_W-1:2]};
        end else if (wr_en) begin
            sr_q <= (sr_q & ~SR_WMASK) | (wr_data & SR_WMASK);
        end
    end

    p_push_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (sr_q[MODE_W-1:0] == {$past(sr_q[KEEP_LO-1:0]), 2'b00}) &&
                 (sr_q[XW-1:MODE_W] == $past(sr_q[XW-1:MODE_W])));

    p_pop_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> sr_q[MODE_W-1:0] ==
                           {$past(sr_q[MODE_W-1:KEEP_LO]), $past(sr_q[MODE_W-1:2])});
endmodule

// File: rtl/cp0_irq_pend.sv
`timescale 1ns/1ps
module cp0_irq_pend #(
    parameter int NIRQ = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] lines,
    input  logic            step,
    output logic [NIRQ-1:0] pend_q,
    output logic            hold_q
);
    logic new_edge;
    assign new_edge = |(lines & ~pend_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            hold_q <= 1'b0;
        end else begin
            pend_q <= lines;
            if (new_edge)
                hold_q <= 1'b1;
            else if (step)
                hold_q <= 1'b0;
        end
    end

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        new_edge |=> hold_q);

    p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lines[0]) |=> pend_q[0]);
endmodule

// File: rtl/cp0_trap_fsm.sv
`timescale 1ns/1ps
module cp0_trap_fsm
    import cp0_trap_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [XW-1:0] vec_in,
    output logic          in_run,
    output logic          redirect_vld,
    output logic [XW-1:0] redirect_pc
);
    trap_st_e      state_q, state_d;
    logic [XW-1:0] vec_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_RUN;
            ST_RUN:   state_d = fire ? ST_REDIR : ST_RUN;
            ST_REDIR: state_d = ST_RUN;
            default:  state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (fire && state_q == ST_RUN)
                vec_q <= vec_in;
        end
    end

    always_comb begin
        in_run       = 1'b0;
        redirect_vld = 1'b0;
        redirect_pc  = vec_q;
        unique case (state_q)
            ST_BOOT: begin
                redirect_vld = 1'b1;
                redirect_pc  = BOOT_PC;
            end
            ST_RUN:   in_run = 1'b1;
            ST_REDIR: redirect_vld = 1'b1;
            default:  redirect_vld = 1'b0;
        endcase
    end

    p_redir_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |=> !redirect_vld);

    p_fire_redir_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && in_run) |=> redirect_vld);

    p_vec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |-> (redirect_pc == BOOT_PC || redirect_pc == VEC_BOOT ||
                          redirect_pc == VEC_NORM));
endmodule

// File: rtl/cp0_trap_unit.sv
`timescale 1ns/1ps
module cp0_trap_unit
    import cp0_trap_pkg::*;
#(
    parameter int NIRQ    = 6,
    parameter int IRQ_LSB = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_req,
    input  logic [4:0]      exc_code,
    input  logic [31:0]     exc_pc,
    input  logic [31:0]     fetch_pc,
    input  logic            in_delay,
    input  logic            br_taken,
    input  logic [1:0]      cop_num,
    input  logic            br_chk,
    input  logic [31:0]     br_tgt,
    input  logic [NIRQ-1:0] irq_lines,
    input  logic            insn_step,
    input  logic            rfe,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [4:0]      reg_idx,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            redirect_vld,
    output logic [31:0]     redirect_pc
);
    localparam int IP_LO = 8;
    localparam int IP_HI = 15;

    logic [XW-1:0] sr_q, cause_q, cause_rd, rpc_q, fadr_q, jtgt_q, dbg_q;
    logic [XW-1:0] bkpc_q, bkda_q, bkdm_q, bkpm_q;
    logic [NIRQ-1:0] pend_q;
    logic hold_q, in_run;

    logic          mis_tgt, bad_rd, int_take, any_req, fire;
    logic [4:0]    t_code;
    logic          t_bd, t_bt, t_fadr;
    logic [1:0]    t_ce;
    logic [XW-1:0] t_pc, vec;
    logic          sw_wr, sw_rfe;

    always_comb begin
        cause_rd = cause_q;
        cause_rd[IRQ_LSB +: NIRQ] = pend_q;
    end

    assign mis_tgt  = br_chk && (br_tgt[1:0] != 2'b00);
    assign bad_rd   = reg_rd && !idx_known(reg_idx);
    assign int_take = sr_q[0] && !hold_q && |(cause_rd[IP_HI:IP_LO] & sr_q[IP_HI:IP_LO]);
    assign any_req  = exc_req || mis_tgt || bad_rd || int_take;
    assign fire     = in_run && any_req;
    assign vec      = sr_q[SR_BEV] ? VEC_BOOT : VEC_NORM;
    assign sw_wr    = in_run && reg_wr && !fire;
    assign sw_rfe   = in_run && rfe && !fire;

    always_comb begin
        t_code = CODE_INT;
        t_bd   = in_delay;
        t_bt   = br_taken;
        t_ce   = 2'b00;
        t_pc   = exc_pc;
        t_fadr = 1'b0;
        if (exc_req) begin
            t_code = exc_code;
            t_ce   = cop_num;
        end else if (mis_tgt) begin
            t_code = CODE_ALGN;
            t_bd   = 1'b0;
            t_bt   = 1'b0;
            t_pc   = br_tgt;
            t_fadr = 1'b1;
        end else if (bad_rd) begin
            t_code = CODE_RSVD;
            t_ce   = cop_num;
        end
    end

    cp0_status_reg u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (fire),
        .pop     (sw_rfe),
        .wr_en   (sw_wr && reg_idx == IX_STAT),
        .wr_data (reg_wdata),
        .sr_q    (sr_q)
    );

    cp0_irq_pend #(.NIRQ(NIRQ)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines  (irq_lines),
        .step   (insn_step),
        .pend_q (pend_q),
        .hold_q (hold_q)
    );

    cp0_trap_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fire         (fire),
        .vec_in       (vec),
        .in_run       (in_run),
        .redirect_vld (redirect_vld),
        .redirect_pc  (redirect_pc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            rpc_q   <= '0;
            fadr_q  <= '0;
            jtgt_q  <= '0;
            dbg_q   <= '0;
            bkpc_q  <= '0;
            bkda_q  <= '0;
            bkdm_q  <= '0;
            bkpm_q  <= '0;
        end else if (fire) begin
            cause_q <= (cause_q & ~TRAP_WMASK) |
                       (trap_word(t_code, t_bd, t_bt, t_ce) & TRAP_WMASK);
            rpc_q   <= t_bd ? (t_pc - 32'd4) : t_pc;
            if (t_bd)
                jtgt_q <= fetch_pc;
            if (t_fadr)
                fadr_q <= br_tgt;
        end else if (sw_wr) begin
            case (reg_idx)
                IX_BKPC:  bkpc_q  <= reg_wdata;
                IX_BKDA:  bkda_q  <= reg_wdata;
                IX_BKDM:  bkdm_q  <= reg_wdata;
                IX_BKPM:  bkpm_q  <= reg_wdata;
                IX_DBG:   dbg_q   <= (dbg_q & ~DBG_WMASK) | (reg_wdata & DBG_WMASK);
                IX_CAUSE: cause_q <= (cause_q & ~CA_WMASK) | (reg_wdata & CA_WMASK);
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (reg_idx)
            IX_BKPC:  reg_rdata = bkpc_q;
            IX_BKDA:  reg_rdata = bkda_q;
            IX_JTGT:  reg_rdata = jtgt_q;
            IX_DBG:   reg_rdata = dbg_q;
            IX_FADR:  reg_rdata = fadr_q;
            IX_BKDM:  reg_rdata = bkdm_q;
            IX_BKPM:  reg_rdata = bkpm_q;
            IX_STAT:  reg_rdata = sr_q;
            IX_CAUSE: reg_rdata = cause_rd;
            IX_RPC:   reg_rdata = rpc_q;
            IX_PID:   reg_rdata = PRID_VAL;
            default:  reg_rdata = '0;
        endcase
    end

    p_slot_rpc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && exc_req && in_delay) |=> rpc_q == $past(exc_pc) - 32'd4);

    p_exc_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && exc_req) |=> cause_q[6:2] == $past(exc_code));

    p_align_fadr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !exc_req && mis_tgt) |=> (fadr_q == $past(br_tgt)) && (rpc_q == $past(br_tgt)));

    p_jtgt_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && reg_idx == IX_JTGT) |=> $stable(jtgt_q));

    p_redir_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_vld && exc_req) |=> $stable(rpc_q));
endmodule

// File: tb/cp0_trap_unit_tb.sv
`timescale 1ns/1ps
module cp0_trap_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [31:0] exc_pc = '0;
    logic [31:0] fetch_pc = '0;
    logic        in_delay = 1'b0;
    logic        br_taken = 1'b0;
    logic [1:0]  cop_num = '0;
    logic        br_chk = 1'b0;
    logic [31:0] br_tgt = '0;
    logic [5:0]  irq_lines = '0;
    logic        insn_step = 1'b0;
    logic        rfe = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        redirect_vld;
    logic [31:0] redirect_pc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cp0_trap_unit dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .exc_pc(exc_pc), .fetch_pc(fetch_pc), .in_delay(in_delay),
        .br_taken(br_taken), .cop_num(cop_num), .br_chk(br_chk), .br_tgt(br_tgt),
        .irq_lines(irq_lines), .insn_step(insn_step), .rfe(rfe), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .redirect_vld(redirect_vld), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] ix, input logic [31:0] exp, input string req);
        reg_idx = ix;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [4:0] ix, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = ix; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rfe();
        @(negedge clk);
        rfe = 1'b1;
        @(negedge clk);
        rfe = 1'b0;
    endtask

    task automatic clear_req();
        exc_req = 1'b0; br_chk = 1'b0; reg_rd = 1'b0;
        in_delay = 1'b0; br_taken = 1'b0; cop_num = '0;
    endtask

    task automatic expect_redirect(input logic [31:0] pc, input string req);
        @(negedge clk);
        clear_req();
        chk({req, " redirect"}, {31'd0, redirect_vld}, 32'd1);
        chk({req, " vector"}, redirect_pc, pc);
        @(negedge clk);
        chk("R12 pulse ends", {31'd0, redirect_vld}, 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 redirect in reset", {31'd0, redirect_vld}, 32'd1);
        rst_n = 1'b1;
        chk("R1 boot pc", redirect_pc, 32'hBFC0_0000);
        @(negedge clk);
        chk("R1 boot pulse ends", {31'd0, redirect_vld}, 32'd0);
        rd(5'd12, 32'h0, "R1 status");
        rd(5'd13, 32'h0, "R1 cause");
        rd(5'd14, 32'h0, "R1 return pc");
        rd(5'd8,  32'h0, "R1 fault addr");
        rd(5'd3,  32'h0, "R1 breakpoint");
        rd(5'd15, 32'h2, "R9 processor id");
    endtask

    task automatic t_masks();
        wr(5'd12, 32'hFFFF_FFFF);
        rd(5'd12, 32'hF04F_FF3F, "R8 status mask");
        wr(5'd12, 32'h0);
        wr(5'd13, 32'hFFFF_FFFF);
        rd(5'd13, 32'h0000_0300, "R8 cause mask");
        wr(5'd7, 32'hFFFF_FFFF);
        rd(5'd7, 32'hFF80_F03F, "R8 debug mask");
        wr(5'd6, 32'h1234_5678);
        rd(5'd6, 32'h0, "R9 jump target ignores write");
        wr(5'd11, 32'hA5A5_5A5A);
        rd(5'd11, 32'hA5A5_5A5A, "R13 bp pc mask index");
        wr(5'd12, 32'h3);
    endtask

    task automatic t_plain_exc();
        @(negedge clk);
        exc_req = 1'b1; exc_code = 5'd8; exc_pc = 32'h8000_1000; cop_num = 2'd2;
        @(negedge clk);
        clear_req();
        chk("R2 normal vector", redirect_pc, 32'h8000_0080);
        chk("R12 redirect", {31'd0, redirect_vld}, 32'd1);
        exc_req = 1'b1; exc_code = 5'd3; exc_pc = 32'h8000_F000;
        @(negedge clk);
        clear_req();
        chk("R12 ignored during redirect", {31'd0, redirect_vld}, 32'd0);
        rd(5'd14, 32'h8000_1000, "R3 return pc");
        rd(5'd13, 32'h2000_0320, "R3 cause fields");
        rd(5'd12, 32'h0000_000C, "R5 stack push");
        do_rfe();
        rd(5'd12, 32'h0000_0003, "R6 stack pop");
    endtask

    task automatic t_delay_slot();
        wr(5'd12, 32'h0040_0003);
        @(negedge clk);
        exc_req = 1'b1; exc_code = 5'd12; exc_pc = 32'h8000_2000;
        fetch_pc = 32'h8000_3000; in_delay = 1'b1; br_taken = 1'b1;
        expect_redirect(32'hBFC0_0180, "R2 boot vector");
        rd(5'd14, 32'h8000_1FFC, "R4 return pc minus 4");
        rd(5'd6,  32'h8000_3000, "R4 jump target");
        rd(5'd13, 32'hC000_0330, "R4 cause delay bits");
        rd(5'd12, 32'h0040_000C, "R5 push keeps upper bits");
    endtask

    task automatic t_misalign();
        @(negedge clk);
        br_chk = 1'b1; br_tgt = 32'h8000_4002;
        expect_redirect(32'hBFC0_0180, "R7 misaligned");
        rd(5'd14, 32'h8000_4002, "R7 return pc");
        rd(5'd8,  32'h8000_4002, "R7 fault addr");
        rd(5'd13, 32'h0000_0310, "R7 cause");
        rd(5'd12, 32'h0040_0030, "R5 second push");
        wr(5'd12, 32'h1);
    endtask

    task automatic t_bad_read();
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = 5'd20; exc_pc = 32'h8000_5000;
        expect_redirect(32'h8000_0080, "R9 unknown read");
        rd(5'd13, 32'h0000_0328, "R9 reserved code");
        rd(5'd14, 32'h8000_5000, "R9 return pc");
        do_rfe();
        rd(5'd12, 32'h1, "R6 pop after read trap");
    endtask

    task automatic t_irq();
        wr(5'd12, 32'h0000_0401);
        @(negedge clk);
        irq_lines = 6'b000001; exc_pc = 32'h8000_6000;
        @(negedge clk);
        rd(5'd13, 32'h0000_0728, "R10 pending bit");
        chk("R10 held off", {31'd0, redirect_vld}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R10 still held", {31'd0, redirect_vld}, 32'd0);
        insn_step = 1'b1;
        @(negedge clk);
        insn_step = 1'b0;
        chk("R10 hold released", {31'd0, redirect_vld}, 32'd0);
        @(negedge clk);
        chk("R10 interrupt taken", {31'd0, redirect_vld}, 32'd1);
        chk("R10 vector", redirect_pc, 32'h8000_0080);
        @(negedge clk);
        rd(5'd14, 32'h8000_6000, "R10 return pc");
        rd(5'd13, 32'h0000_0700, "R10 cause code 0");
        rd(5'd12, 32'h0000_0404, "R5 interrupt push");
        irq_lines = '0;
        @(negedge clk);
        rd(5'd13, 32'h0000_0300, "R10 pending clears");
        do_rfe();
        chk("R10 no trap after clear", {31'd0, redirect_vld}, 32'd0);
    endtask

    task automatic t_priority();
        wr(5'd12, 32'h0000_0400);
        @(negedge clk);
        irq_lines = 6'b000001;
        @(negedge clk);
        insn_step = 1'b1;
        @(negedge clk);
        insn_step = 1'b0;
        wr(5'd12, 32'h0000_0401);
        exc_req = 1'b1; exc_code = 5'd9; exc_pc = 32'h8000_7000;
        br_chk = 1'b1; br_tgt = 32'h8000_8001;
        expect_redirect(32'h8000_0080, "R11 priority");
        rd(5'd13, 32'h0000_0724, "R11 exc code wins");
        rd(5'd14, 32'h8000_7000, "R11 return pc");
        rd(5'd8,  32'h8000_4002, "R11 fault addr untouched");
        irq_lines = '0;
        do_rfe();
        rd(5'd12, 32'h0000_0401, "R6 pop restores");
    endtask

    initial begin
        t_reset();
        t_masks();
        t_plain_exc();
        t_delay_slot();
        t_misalign();
        t_bad_read();
        t_irq();
        t_priority();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R12 actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule